// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the byte address for a single-register memory transfer and the value the base register should hold afterwards. A byte offset is taken either from a 12-bit immediate or from a register value shifted left by 0 to 31 places. That offset is then added to or subtracted from the base. Address arithmetic wraps modulo 2^32.

Three indexing behaviours are supported:

- **Pre-indexed, no writeback:** the sum is used as the access address and the base is kept.
- **Pre-indexed with writeback:** the sum is both the access address and the new base.
- **Post-indexed:** the unmodified base is the access address, and the sum always becomes the new base.

A misalignment flag reports whether the access address suits the requested size.

The result is computed combinationally. An optional output register stage (`OUT_REG`, enabled by default) lets the unit sit at a pipeline boundary. With it enabled, results appear one clock after the operands are presented.

Top module: `addr_gen_unit`

## Requirements
- R1: With `off_is_reg` = 0, the offset is `imm_off` zero-extended to 32 bits.
- R2: With `off_is_reg` = 1, the offset is `reg_off` shifted left by `shamt` (0 to 31). Bits moved above bit 31 are dropped.
- R3: With `sub_off` = 1, the offset is subtracted from the base; otherwise it is added. Results wrap modulo 2^32 without any indication.
- R4: Pre-indexed (`post_idx` = 0) with `wb_req` = 0: `acc_addr` = base±offset, `new_base` = base, `base_we` = 0.
- R5: Pre-indexed with `wb_req` = 1: `acc_addr` and `new_base` both equal base±offset, and `base_we` = 1.
- R6: Post-indexed (`post_idx` = 1): `acc_addr` = base, `new_base` = base±offset, and `base_we` = 1 whatever `wb_req` is.
- R7: `acc_size` encoding: 00 byte, 01 halfword, 10 and 11 word. `misalign` is set for a halfword when `acc_addr[0]` = 1, and for a word when `acc_addr[1:0]` != 0. It is never set for a byte.
- R8: With `OUT_REG` = 1, every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| base_val | input | 32 | Base register value |
| off_is_reg | input | 1 | 1 selects the shifted register offset, 0 selects the immediate |
| imm_off | input | 12 | Unsigned immediate offset |
| reg_off | input | 32 | Register offset value |
| shamt | input | 5 | Left shift applied to the register offset |
| sub_off | input | 1 | 1 subtracts the offset, 0 adds it |
| post_idx | input | 1 | 1 post-indexed, 0 pre-indexed |
| wb_req | input | 1 | Writeback request for pre-indexed accesses |
| acc_size | input | 2 | Access size code |
| acc_addr | output | 32 | Address for the memory access |
| new_base | output | 32 | Updated base value |
| base_we | output | 1 | Base writeback enable |
| misalign | output | 1 | Access address does not suit the size |

## Verification
The clocked properties compare each output with operands sampled one edge earlier. They therefore assume that the inputs are steady around the rising edge and that at least one edge has passed since reset. The stimulus drives all operands on the falling edge only and checks results one edge later. Every input is treated as meaningful in every cycle, so random operands need no filtering. The directed cases cover wrap-around, the largest shift and every size code at each low-address pattern.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int AW = 32;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] nbase;
        logic          we;
        logic          mis;
    } agu_res_t;
endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
    parameter int AW    = 32,
    parameter int IMM_W = 12,
    parameter int SH_W  = $clog2(AW)
) (
    input  logic             off_is_reg,
    input  logic [IMM_W-1:0] imm_off,
    input  logic [AW-1:0]    reg_off,
    input  logic [SH_W-1:0]  shamt,
    output logic [AW-1:0]    offset
);
    localparam int PAD_W = AW - IMM_W;

    logic [AW-1:0] shifted;

    always_comb begin
        shifted = reg_off << shamt;
        if (off_is_reg) offset = shifted;
        else            offset = {{PAD_W{1'b0}}, imm_off};
    end
endmodule

// File: rtl/agu_adder.sv
module agu_adder #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    input  logic          sub,
    output logic [AW-1:0] sum
);
    // One adder serves both directions: invert the operand and carry in one.
    logic [AW-1:0] operand;
    logic [AW-1:0] carry_in;

    always_comb begin
        operand  = offset ^ {AW{sub}};
        carry_in = {{(AW-1){1'b0}}, sub};
        sum      = base + operand + carry_in;
    end
endmodule

// File: rtl/agu_align.sv
module agu_align #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output logic          mis
);
    import agu_pkg::*;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE:          mis = 1'b0;
            SZ_HALF:          mis = addr[0];
            SZ_WORD, SZ_WORD2: mis = |addr[1:0];
            default:          mis = 1'b0;
        endcase
    end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
    parameter int AW      = agu_pkg::AW,
    parameter int IMM_W   = 12,
    parameter int SH_W    = $clog2(AW),
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    base_val,
    input  logic             off_is_reg,
    input  logic [IMM_W-1:0] imm_off,
    input  logic [AW-1:0]    reg_off,
    input  logic [SH_W-1:0]  shamt,
    input  logic             sub_off,
    input  logic             post_idx,
    input  logic             wb_req,
    input  logic [1:0]       acc_size,
    output logic [AW-1:0]    acc_addr,
    output logic [AW-1:0]    new_base,
    output logic             base_we,
    output logic             misalign
);
    import agu_pkg::*;

    logic [AW-1:0] offset;
    logic [AW-1:0] sum;
    logic [AW-1:0] addr_sel;
    logic          mis_d;
    agu_res_t      res_d;
    agu_res_t      res_q;

    agu_offset #(.AW(AW), .IMM_W(IMM_W), .SH_W(SH_W)) u_offset (
        .off_is_reg (off_is_reg),
        .imm_off    (imm_off),
        .reg_off    (reg_off),
        .shamt      (shamt),
        .offset     (offset)
    );

    agu_adder #(.AW(AW)) u_adder (
        .base   (base_val),
        .offset (offset),
        .sub    (sub_off),
        .sum    (sum)
    );

    assign addr_sel = post_idx ? base_val : sum;

    agu_align #(.AW(AW)) u_align (
        .addr (addr_sel),
        .size (acc_size),
        .mis  (mis_d)
    );

    always_comb begin
        res_d.addr  = addr_sel;
        res_d.we    = post_idx | wb_req;
        res_d.nbase = res_d.we ? sum : base_val;
        res_d.mis   = mis_d;
    end

    generate
        if (OUT_REG) begin : g_reg
            logic primed_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q    <= '0;
                    primed_q <= 1'b0;
                end else begin
                    res_q    <= res_d;
                    primed_q <= 1'b1;
                end
            end

            // R6
            post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (primed_q && $past(post_idx)) |-> (acc_addr == $past(base_val)));

            // R6
            post_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (primed_q && $past(post_idx)) |-> base_we);

            // R4
            pre_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (primed_q && !$past(post_idx) && !$past(wb_req))
                    |-> (!base_we && new_base == $past(base_val)));

            // R5
            pre_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (primed_q && !$past(post_idx) && $past(wb_req))
                    |-> (base_we && new_base == acc_addr));

            // R7
            byte_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (primed_q && $past(acc_size) == 2'b00) |-> !misalign);

            // R7
            mis_lowbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                misalign |-> (acc_addr[1:0] != 2'b00));
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign acc_addr = res_q.addr;
    assign new_base = res_q.nbase;
    assign base_we  = res_q.we;
    assign misalign = res_q.mis;
endmodule

// File: tb/addr_gen_unit_test.sv
module addr_gen_unit_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] nbase;
        logic        we;
        logic        mis;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_val = '0;
    logic        off_is_reg = 1'b0;
    logic [11:0] imm_off = '0;
    logic [31:0] reg_off = '0;
    logic [4:0]  shamt = '0;
    logic        sub_off = 1'b0;
    logic        post_idx = 1'b0;
    logic        wb_req = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_addr;
    logic [31:0] new_base;
    logic        base_we;
    logic        misalign;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_gen_unit uut (
        .clk(clk), .rst_n(rst_n), .base_val(base_val), .off_is_reg(off_is_reg),
        .imm_off(imm_off), .reg_off(reg_off), .shamt(shamt), .sub_off(sub_off),
        .post_idx(post_idx), .wb_req(wb_req), .acc_size(acc_size),
        .acc_addr(acc_addr), .new_base(new_base), .base_we(base_we), .misalign(misalign)
    );

    function automatic exp_t model(logic [31:0] b, logic isreg, logic [11:0] imm,
                                   logic [31:0] ro, logic [4:0] sh, logic sb,
                                   logic post, logic wb, logic [1:0] sz, string tag);
        exp_t e;
        logic [63:0] wide;
        logic [31:0] off;
        logic [31:0] s;
        if (isreg) begin
            wide = {32'd0, ro} * (64'd1 << sh);
            off  = wide[31:0];
        end else begin
            off = 32'(imm);
        end
        s = sb ? (b - off) : (b + off);
        e.addr  = post ? b : s;
        e.we    = post || wb;
        e.nbase = e.we ? s : b;
        if (sz == 2'b00)      e.mis = 1'b0;
        else if (sz == 2'b01) e.mis = e.addr[0];
        else                  e.mis = (e.addr % 4) != 0;
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(logic [31:0] b, logic isreg, logic [11:0] imm, logic [31:0] ro,
                         logic [4:0] sh, logic sb, logic post, logic wb, logic [1:0] sz,
                         string tag);
        @(negedge clk);
        base_val = b; off_is_reg = isreg; imm_off = imm; reg_off = ro; shamt = sh;
        sub_off = sb; post_idx = post; wb_req = wb; acc_size = sz;
        q.push_back(model(b, isreg, imm, ro, sh, sb, post, wb, sz, tag));
    endtask

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: compares one edge after each drive (R8 latency).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "acc_addr", acc_addr, e.addr);
                check(e.tag, "new_base", new_base, e.nbase);
                check(e.tag, "base_we", 32'(base_we), 32'(e.we));
                check(e.tag, "misalign", 32'(misalign), 32'(e.mis));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        base_val = 32'hDEAD_BEEF; wb_req = 1'b1; post_idx = 1'b1;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8", "reset acc_addr", acc_addr, 32'h0);
        check("R8", "reset new_base", new_base, 32'h0);
        check("R8", "reset flags", {30'd0, base_we, misalign}, 32'h0);
        rst_n = 1'b1;

        // R4 / R3: pre-index without writeback, subtract 4 from 0x200
        drive(32'h200, 0, 12'd4, 0, 0, 1, 0, 0, 2'b10, "R4");
        // R5 / R3: same with writeback
        drive(32'h200, 0, 12'd4, 0, 0, 1, 0, 1, 2'b10, "R5");
        // R6: post-index +12, writeback irrespective of wb_req
        drive(32'h200, 0, 12'd12, 0, 0, 0, 1, 0, 2'b10, "R6");
        // R2: register 3 shifted by 2, post-indexed
        drive(32'h200, 1, 12'hFFF, 32'd3, 5'd2, 0, 1, 1, 2'b10, "R2");
        // R2: shift 31 drops upper bits
        drive(32'h0, 1, 12'd0, 32'd3, 5'd31, 0, 0, 1, 2'b10, "R2");
        // R1: immediate 0xFFF zero-extended
        drive(32'h1000, 0, 12'hFFF, 32'hFFFF_FFFF, 5'd7, 0, 0, 1, 2'b00, "R1");
        // R3: wrap upward and downward
        drive(32'hFFFF_FFFC, 0, 12'd8, 0, 0, 0, 0, 1, 2'b10, "R3");
        drive(32'h0, 0, 12'd4, 0, 0, 1, 0, 0, 2'b10, "R3");
        // R7: every size code against every low-address pattern
        for (int a = 0; a < 4; a++)
            for (int s = 0; s < 4; s++)
                drive(32'h400 + 32'(a), 0, 12'd0, 0, 0, 0, 0, 0, 2'(s), "R7");
        // random mix covering R1-style and R2-style offsets
        for (int i = 0; i < 300; i++)
            drive($urandom, 1'($urandom), 12'($urandom), $urandom, 5'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                  "R4R5R6 random");
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule